// File: doc/BRIEF.md
# Super I/O index/data configuration port

This block holds a bank of byte-wide configuration entries for an on-chip peripheral controller. Software reaches the bank through a two-byte I/O window. A write to the lower byte of the window selects an entry: the byte is loaded into an index register. An access to the upper byte then reads or writes the entry that the index points at. A read of either byte returns the selected entry on a registered output.

Not every entry can be written. A parameter marks a set of entries as fully read-only. The two serial-port base entries accept only the one base address the serial logic supports; any other value written to them is dropped.

The window starts closed after reset. A configuration write from the host bridge opens or closes it. That write targets one bridge offset, and the value of one bit in its data decides the state. While the window is closed, reads give all-ones and writes change nothing.

Top module: `sio_cfg_port`

## Requirements
- R1: After a synchronous reset, entry 0xE0 is 0x3C, 0xE2 is 0x03, 0xE3 is 0xFC, 0xE6 is 0xDE, 0xE7 is 0xFE and 0xE8 is 0xBE. Every other entry is 0x00, the index register is 0x00, the window is closed and io_rdata is 0xFF.
- R2: A bridge write (brg_cfg_we) at offset 0x85 opens the window from the next cycle when bit 1 of brg_cfg_wdata is 1, and closes it when that bit is 0. Bridge writes at any other offset leave the window state unchanged.
- R3: While the window is open, a write at address 0x3F0 loads io_wdata into the index register.
- R4: While the window is open, a read (io_rd) at 0x3F0 or 0x3F1 puts the entry selected by the index on io_rdata at the clock edge that samples the read. The value holds until the next read that is accepted.
- R5: While the window is open, a write at 0x3F1 stores io_wdata into the selected entry, unless R6, R7 or R8 block it.
- R6: Data writes to the read-only indices (by default 0xE0 and 0xE3) are ignored.
- R7: A data write to entry 0xE7 (serial 1 base) is kept only if the value is 0xFE. Any other value is ignored.
- R8: A data write to entry 0xE8 (serial 2 base) is kept only if the value is 0xBE. Any other value is ignored.
- R9: While the window is closed, a read at either window byte returns 0xFF. Writes at either byte change neither the index register nor any entry.
- R10: Accesses at addresses outside 0x3F0..0x3F1 leave the entries and the index register unchanged, and leave io_rdata holding its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Single-byte I/O write strobe |
| io_rd | input | 1 | Single-byte I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered read data |
| brg_cfg_we | input | 1 | Host bridge configuration byte write strobe |
| brg_cfg_off | input | 8 | Host bridge configuration byte offset |
| brg_cfg_wdata | input | 8 | Host bridge configuration write byte |

## Verification
The bench builds the block with its default parameters: an 8-bit index, so 256 entries, base 0x3F0, and read-only indices 0xE0 and 0xE3. With 256 entries, every index can be swept for both reset contents and write filtering, so each protected and filtered entry is visited, not just sampled. The bench also covers these cases:
- closing the window with a bridge byte whose bit 1 is clear while other bits are set;
- a bridge write to a neighbouring offset, which must not open the window;
- writes made while the window is closed, followed by a check that the index and entries survived;
- accesses one address below and one above the window;
- a second reset taken from a state with a non-zero index.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_INDEX = 2'd1,
    SEL_DATA  = 2'd2
  } win_sel_e;

  function automatic logic [7:0] reset_value(input logic [7:0] idx);
    case (idx)
      8'hE0:   reset_value = 8'h3C;
      8'hE2:   reset_value = 8'h03;
      8'hE3:   reset_value = 8'hFC;
      8'hE6:   reset_value = 8'hDE;
      8'hE7:   reset_value = 8'hFE;
      8'hE8:   reset_value = 8'hBE;
      default: reset_value = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sio_enable_gate.sv
module sio_enable_gate #(
  parameter int         OFF_W  = 8,
  parameter int         DATA_W = 8,
  parameter logic [OFF_W-1:0] EN_OFF = 8'h85,
  parameter int         EN_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              win_en
);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_en <= 1'b0;
    end else if (cfg_we && (cfg_off == EN_OFF)) begin
      win_en <= cfg_wdata[EN_BIT];
    end
  end

endmodule

// File: rtl/sio_port_decode.sv
module sio_port_decode
  import sio_cfg_pkg::*;
#(
  parameter int              IO_AW     = 16,
  parameter logic [IO_AW-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic             win_en,
  output logic             idx_we,
  output logic             data_we,
  output logic             rd_hit,
  output logic             rd_open
);

  localparam logic [IO_AW-1:0] DATA_ADDR = BASE_ADDR + IO_AW'(1);

  win_sel_e sel;

  always_comb begin
    if (io_addr == BASE_ADDR)      sel = SEL_INDEX;
    else if (io_addr == DATA_ADDR) sel = SEL_DATA;
    else                           sel = SEL_NONE;
  end

  assign idx_we  = io_wr && win_en && (sel == SEL_INDEX);
  assign data_we = io_wr && win_en && (sel == SEL_DATA);
  assign rd_hit  = io_rd && (sel != SEL_NONE);
  assign rd_open = win_en;

endmodule

// File: rtl/sio_wr_filter.sv
module sio_wr_filter #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter logic [(1<<IDX_W)-1:0] RO_MASK = '0,
  parameter logic [IDX_W-1:0]  SER1_IDX = 8'hE7,
  parameter logic [DATA_W-1:0] SER1_VAL = 8'hFE,
  parameter logic [IDX_W-1:0]  SER2_IDX = 8'hE8,
  parameter logic [DATA_W-1:0] SER2_VAL = 8'hBE
) (
  input  logic              data_we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              mem_we
);

  logic is_ro;
  logic ser1_bad;
  logic ser2_bad;

  assign is_ro    = RO_MASK[idx];
  assign ser1_bad = (idx == SER1_IDX) && (wdata != SER1_VAL);
  assign ser2_bad = (idx == SER2_IDX) && (wdata != SER2_VAL);
  assign mem_we   = data_we && !is_ro && !ser1_bad && !ser2_bad;

endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= DATA_W'(sio_cfg_pkg::reset_value(8'(i)));
      end
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int IO_AW  = 16,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter logic [IO_AW-1:0] BASE_ADDR = 16'h03F0,
  parameter logic [(1<<IDX_W)-1:0] RO_MASK =
    ((1<<IDX_W)'(1) << 8'hE0) | ((1<<IDX_W)'(1) << 8'hE3),
  parameter logic [IDX_W-1:0]  SER1_IDX = 8'hE7,
  parameter logic [DATA_W-1:0] SER1_VAL = 8'hFE,
  parameter logic [IDX_W-1:0]  SER2_IDX = 8'hE8,
  parameter logic [DATA_W-1:0] SER2_VAL = 8'hBE,
  parameter logic [7:0]        EN_OFF   = 8'h85,
  parameter int                EN_BIT   = 1,
  parameter logic [DATA_W-1:0] IDLE_VAL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              brg_cfg_we,
  input  logic [7:0]        brg_cfg_off,
  input  logic [7:0]        brg_cfg_wdata
);

  logic              win_en;
  logic              idx_we;
  logic              data_we;
  logic              rd_hit;
  logic              rd_open;
  logic              mem_we;
  logic [IDX_W-1:0]  index_q;
  logic [DATA_W-1:0] entry_rd;

  sio_enable_gate #(
    .OFF_W (8),
    .DATA_W(8),
    .EN_OFF(EN_OFF),
    .EN_BIT(EN_BIT)
  ) u_gate (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (brg_cfg_we),
    .cfg_off  (brg_cfg_off),
    .cfg_wdata(brg_cfg_wdata),
    .win_en   (win_en)
  );

  sio_port_decode #(
    .IO_AW    (IO_AW),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .io_addr(io_addr),
    .io_wr  (io_wr),
    .io_rd  (io_rd),
    .win_en (win_en),
    .idx_we (idx_we),
    .data_we(data_we),
    .rd_hit (rd_hit),
    .rd_open(rd_open)
  );

  sio_wr_filter #(
    .IDX_W   (IDX_W),
    .DATA_W  (DATA_W),
    .RO_MASK (RO_MASK),
    .SER1_IDX(SER1_IDX),
    .SER1_VAL(SER1_VAL),
    .SER2_IDX(SER2_IDX),
    .SER2_VAL(SER2_VAL)
  ) u_filt (
    .data_we(data_we),
    .idx    (index_q),
    .wdata  (io_wdata),
    .mem_we (mem_we)
  );

  sio_cfg_regfile #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) u_rf (
    .clk  (clk),
    .rst  (rst),
    .we   (mem_we),
    .waddr(index_q),
    .wdata(io_wdata),
    .raddr(index_q),
    .rdata(entry_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
    end else if (idx_we) begin
      index_q <= io_wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= IDLE_VAL;
    end else if (rd_hit) begin
      io_rdata <= rd_open ? entry_rd : IDLE_VAL;
    end
  end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int IO_AW  = 16,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter logic [IO_AW-1:0]  BASE_ADDR = 16'h03F0,
  parameter logic [IDX_W-1:0]  SER1_IDX  = 8'hE7,
  parameter logic [DATA_W-1:0] SER1_VAL  = 8'hFE,
  parameter logic [IDX_W-1:0]  SER2_IDX  = 8'hE8,
  parameter logic [DATA_W-1:0] SER2_VAL  = 8'hBE,
  parameter logic [7:0]        EN_OFF    = 8'h85,
  parameter int                EN_BIT    = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [IO_AW-1:0]  io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [DATA_W-1:0] io_wdata,
  input logic [DATA_W-1:0] io_rdata,
  input logic              brg_cfg_we,
  input logic [7:0]        brg_cfg_off,
  input logic [7:0]        brg_cfg_wdata,
  input logic              win_en,
  input logic [IDX_W-1:0]  index_q,
  input logic              mem_we
);

  logic in_win;
  logic rst_seen_q;

  assign in_win = (io_addr == BASE_ADDR) || (io_addr == BASE_ADDR + IO_AW'(1));

  always_ff @(posedge clk) rst_seen_q <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_seen_q && !rst) begin
      reset_state_chk: assert (io_rdata == '1 && index_q == '0 && !win_en);
    end
  end

  // R2
  bridge_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (brg_cfg_we && brg_cfg_off == EN_OFF) |=> (win_en == $past(brg_cfg_wdata[EN_BIT])));

  // R2
  bridge_other_chk: assert property (@(posedge clk) disable iff (rst)
    !(brg_cfg_we && brg_cfg_off == EN_OFF) |=> $stable(win_en));

  // R3
  index_load_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && win_en && io_addr == BASE_ADDR) |=> (index_q == $past(io_wdata[IDX_W-1:0])));

  // R7
  ser1_filter_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && index_q == SER1_IDX) |-> (io_wdata == SER1_VAL));

  // R8
  ser2_filter_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && index_q == SER2_IDX) |-> (io_wdata == SER2_VAL));

  // R9
  closed_read_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && in_win && !win_en) |=> (io_rdata == '1));

  // R9
  closed_write_chk: assert property (@(posedge clk) disable iff (rst)
    !win_en |-> !mem_we);

  // R10
  outside_read_chk: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && in_win) |=> $stable(io_rdata));

  // R10
  outside_index_chk: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && in_win) |=> $stable(index_q));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .IO_AW    (IO_AW),
  .IDX_W    (IDX_W),
  .DATA_W   (DATA_W),
  .BASE_ADDR(BASE_ADDR),
  .SER1_IDX (SER1_IDX),
  .SER1_VAL (SER1_VAL),
  .SER2_IDX (SER2_IDX),
  .SER2_VAL (SER2_VAL),
  .EN_OFF   (EN_OFF),
  .EN_BIT   (EN_BIT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .io_addr      (io_addr),
  .io_wr        (io_wr),
  .io_rd        (io_rd),
  .io_wdata     (io_wdata),
  .io_rdata     (io_rdata),
  .brg_cfg_we   (brg_cfg_we),
  .brg_cfg_off  (brg_cfg_off),
  .brg_cfg_wdata(brg_cfg_wdata),
  .win_en       (win_en),
  .index_q      (index_q),
  .mem_we       (mem_we)
);

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/1ps
module sim_sio_cfg_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        brg_cfg_we = 1'b0;
  logic [7:0]  brg_cfg_off = '0;
  logic [7:0]  brg_cfg_wdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] model [256];
  logic [7:0] rv;

  always #4 clk = ~clk;

  sio_cfg_port u0 (
    .clk          (clk),
    .rst          (rst),
    .io_addr      (io_addr),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_wdata     (io_wdata),
    .io_rdata     (io_rdata),
    .brg_cfg_we   (brg_cfg_we),
    .brg_cfg_off  (brg_cfg_off),
    .brg_cfg_wdata(brg_cfg_wdata)
  );

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      8'hE0: return 8'h3C;
      8'hE2: return 8'h03;
      8'hE3: return 8'hFC;
      8'hE6: return 8'hDE;
      8'hE7: return 8'hFE;
      8'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit accepts(input int i, input logic [7:0] v);
    if (i == 8'hE0 || i == 8'hE3) return 1'b0;
    if (i == 8'hE7 && v != 8'hFE) return 1'b0;
    if (i == 8'hE8 && v != 8'hBE) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    brg_cfg_off = off; brg_cfg_wdata = d; brg_cfg_we = 1'b1;
    @(negedge clk);
    brg_cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 256; i++) model[i] = rst_val(i);
  endtask

  task automatic sel_read(input int i, output logic [7:0] d);
    io_write(16'h03F0, 8'(i));
    io_read(16'h03F1, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0x00 expected 0x01");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 rdata at reset", io_rdata, 8'hFF);
    io_read(16'h03F1, rv);
    check("R1 window closed after reset", rv, 8'hFF);

    cfg_write(8'h84, 8'h02);
    io_read(16'h03F1, rv);
    check("R2 other offset keeps closed", rv, 8'hFF);

    cfg_write(8'h85, 8'h02);
    io_read(16'h03F1, rv);
    check("R1 index resets to 0", rv, 8'h00);

    // R1 R3 R4 reset contents sweep
    for (int i = 0; i < 256; i++) begin
      sel_read(i, rv);
      check("R1 R4 reset entry", rv, rst_val(i));
    end

    // R5 R6 R7 R8 write sweep
    for (int i = 0; i < 256; i++) begin
      logic [7:0] v;
      v = 8'(i) ^ 8'hA5;
      io_write(16'h03F0, 8'(i));
      io_write(16'h03F1, v);
      if (accepts(i, v)) model[i] = v;
    end
    for (int i = 0; i < 256; i++) begin
      sel_read(i, rv);
      check("R5 R6 R7 R8 written entry", rv, model[i]);
    end

    // R7 R8 cross values
    io_write(16'h03F0, 8'hE7);
    io_write(16'h03F1, 8'hBE);
    io_read(16'h03F1, rv);
    check("R7 serial1 rejects 0xBE", rv, 8'hFE);
    io_write(16'h03F1, 8'hFE);
    io_read(16'h03F1, rv);
    check("R7 serial1 keeps 0xFE", rv, 8'hFE);
    io_write(16'h03F0, 8'hE8);
    io_write(16'h03F1, 8'hFE);
    io_read(16'h03F1, rv);
    check("R8 serial2 rejects 0xFE", rv, 8'hBE);
    io_write(16'h03F0, 8'hE0);
    io_write(16'h03F1, 8'h00);
    io_read(16'h03F0, rv);
    check("R6 read-only 0xE0 and R4 read at index byte", rv, 8'h3C);

    // R9 closed window
    io_write(16'h03F0, 8'h10);
    cfg_write(8'h85, 8'hFD);
    io_read(16'h03F1, rv);
    check("R9 closed read data byte", rv, 8'hFF);
    io_read(16'h03F0, rv);
    check("R9 closed read index byte", rv, 8'hFF);
    io_write(16'h03F0, 8'h20);
    io_write(16'h03F1, 8'h99);
    cfg_write(8'h85, 8'h02);
    io_read(16'h03F1, rv);
    check("R9 index and entry kept while closed", rv, model[16]);
    io_write(16'h03F0, 8'h20);
    io_read(16'h03F1, rv);
    check("R9 entry 0x20 untouched", rv, model[32]);

    // R10 outside window
    io_write(16'h03F0, 8'h30);
    io_read(16'h03F1, rv);
    check("R10 baseline", rv, model[48]);
    io_write(16'h03F2, 8'h40);
    io_write(16'h03EF, 8'h41);
    io_read(16'h03F2, rv);
    check("R10 outside read holds rdata", rv, model[48]);
    io_read(16'h03F1, rv);
    check("R10 index unchanged by outside writes", rv, model[48]);
    io_write(16'h03F0, 8'h40);
    io_read(16'h03F1, rv);
    check("R10 entry 0x40 unchanged", rv, model[64]);

    // R1 second reset from non-zero index and modified entries
    io_write(16'h03F0, 8'hE2);
    io_write(16'h03F1, 8'h55);
    do_reset();
    check("R1 rdata after second reset", io_rdata, 8'hFF);
    cfg_write(8'h85, 8'h02);
    io_read(16'h03F1, rv);
    check("R1 index back to 0", rv, 8'h00);
    sel_read(8'hE2, rv);
    check("R1 entry 0xE2 restored", rv, 8'h03);
    sel_read(8'h10, rv);
    check("R1 entry 0x10 restored", rv, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule